// File: doc/BRIEF.md
# Single-Stream Direct-Mode DMA Transfer Engine

This block is one DMA stream. It moves a programmed number of data items from a source address to a destination address. Each item is one read on a shared request/response bus followed by one write. One side is a peripheral address and the other is a memory address. Each side has its own item width and its own choice of a fixed or an incrementing address. The engine runs in direct mode: every item read is written straight out, with no internal queue.

Software programs the configuration inputs and pulses `start`. The engine checks the configuration and captures it. For a peripheral direction, it serves one item per request pulse from the peripheral. For a memory-to-memory copy, it runs without any request.

The engine clears its enable in these cases:
- at the end of a normal-mode block;
- on a bus error;
- on a rejected configuration;
- when a stop request has taken effect.

It keeps five sticky status flags, which software clears by writing ones. A single interrupt line combines the flags with their enables.

Top module: `dma_stream_engine`

## Requirements
- R1: `cfg_dir` selects the direction: 0 is peripheral to memory, 1 is memory to peripheral and 2 is memory to memory. In directions 0 and 2 the source is the peripheral address; in direction 1 it is the memory address. Each item is one read of the source followed by one write of the read data to the destination. Direction 2 starts reading with no request. Directions 0 and 1 stay off the bus until a `prq` pulse arrives, and each pulse serves one item.
- R2: The sizes are encoded as 0 for byte, 1 for halfword and 2 for word, and `bus_size` carries that code. After each completed item, a side whose increment enable is set advances by 1, 2 or 4 bytes. A side whose increment enable is clear keeps its start address.
- R3: `items_left` loads the programmed count at start and drops by one per completed item. In normal mode, after the last item, `items_left` is 0, `busy_en` clears and flag bit 0 (complete) sets.
- R4: Flag bit 1 (half) sets on the item that leaves `items_left` equal to the programmed count divided by two, rounded down.
- R5: In circular mode, the last item sets flag bit 0 and reloads the count and both start addresses, and the stream stays enabled.
- R6: A start is rejected in any of these cases:
  - direction code 3;
  - size code 3 on either side;
  - unequal side sizes;
  - a count of 0;
  - an address not aligned to its side's size;
  - memory-to-memory combined with circular mode.

  A rejected start leaves `busy_en` at 0, sets flag bit 4 (configuration/FIFO error) and makes no bus access.
- R7: A `stop` pulse while an item is on the bus takes effect only after that item's write completes, and `busy_en` stays 1 until then. A `stop` pulse while the engine waits for a request clears `busy_en` at the next edge.
- R8: An error response sets flag bit 2 (transfer error), clears `busy_en`, and does not count the item. An error on a read means no write follows.
- R9: A `prq` pulse that arrives while a previous request is pending or being served sets flag bit 3 (direct-mode error). That pulse is dropped.
- R10: A one in `flag_clr` clears the matching flag. A flag that is set and cleared in the same cycle ends up set.
- R11: `irq` is high exactly when some flag is set whose bit in `cfg_ie` is also set.
- R12: The configuration is captured at an accepted start, and later changes to it have no effect on the running stream. A `start` while `busy_en` is 1 is ignored.
- R13: `prq_ack` pulses once per completed item in the peripheral directions, and never in memory-to-memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir | input | 2 | Direction code |
| cfg_psize | input | 2 | Peripheral-side item size code |
| cfg_msize | input | 2 | Memory-side item size code |
| cfg_pinc | input | 1 | Peripheral address increment enable |
| cfg_minc | input | 1 | Memory address increment enable |
| cfg_circ | input | 1 | Circular mode |
| cfg_paddr | input | AW | Peripheral start address |
| cfg_maddr | input | AW | Memory start address |
| cfg_count | input | CW | Item count, in source-side items |
| cfg_ie | input | 5 | Interrupt enable per flag |
| start | input | 1 | Enable pulse |
| stop | input | 1 | Disable request pulse |
| flag_clr | input | 5 | Write-one-to-clear pulses for the flags |
| flags | output | 5 | Sticky flags: 0 complete, 1 half, 2 transfer error, 3 direct-mode error, 4 configuration/FIFO error |
| irq | output | 1 | Interrupt |
| busy_en | output | 1 | Stream enable as seen by software |
| items_left | output | CW | Remaining item count |
| prq | input | 1 | Peripheral request pulse |
| prq_ack | output | 1 | Item served, to the peripheral |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access response |
| bus_err | input | 1 | Error response, valid with `bus_ack` |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |

## Verification
The hardest cases to reach from the ports are the ones that depend on where an item is inside its read/write pair:
- a stop that lands while an item is on the bus;
- a bus error on a read rather than on a write;
- a request pulse that overruns one already being served.

The bench's bus responder acknowledges every other cycle and numbers every response. This lets a chosen response be turned into an error. It also lets the bench issue `stop` or an extra `prq` at the negative edge right after it sees a read request.

A sweep over every direction, size, increment pairing and several short counts predicts each write's address, data, size and the half/complete flags item by item.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

    typedef enum logic [1:0] {
        DIR_P2M = 2'd0,
        DIR_M2P = 2'd1,
        DIR_M2M = 2'd2,
        DIR_BAD = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } state_e;

    typedef struct packed {
        dir_e  dir;
        size_e psize;
        size_e msize;
        logic  pinc;
        logic  minc;
        logic  circ;
    } mode_t;

    localparam int NFLAGS   = 5;
    localparam int FLAG_TC  = 0;
    localparam int FLAG_HT  = 1;
    localparam int FLAG_TE  = 2;
    localparam int FLAG_DME = 3;
    localparam int FLAG_FE  = 4;

    // Bytes moved by one item of the given size.
    function automatic logic [2:0] size_bytes(size_e s);
        case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            SZ_WORD: size_bytes = 3'd4;
            default: size_bytes = 3'd0;
        endcase
    endfunction

    // Low address bits that violate the natural alignment of a size.
    function automatic logic misaligned(logic [1:0] lo, size_e s);
        case (s)
            SZ_HALF: misaligned = lo[0];
            SZ_WORD: misaligned = |lo;
            default: misaligned = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_stream_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  mode_t         mode,
    input  logic [AW-1:0] paddr,
    input  logic [AW-1:0] maddr,
    input  logic [CW-1:0] count,
    output logic          ok
);
    logic dir_ok, size_ok, count_ok, align_ok, mode_ok;

    always_comb begin
        dir_ok   = (mode.dir != DIR_BAD);
        size_ok  = (mode.psize != SZ_BAD) && (mode.msize != SZ_BAD) &&
                   (mode.psize == mode.msize);
        count_ok = (count != '0);
        align_ok = !misaligned(paddr[1:0], mode.psize) &&
                   !misaligned(maddr[1:0], mode.msize);
        mode_ok  = !((mode.dir == DIR_M2M) && mode.circ);
        ok       = dir_ok && size_ok && count_ok && align_ok && mode_ok;
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_stream_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          inc_en,
    input  size_e         size,
    input  logic          step,
    input  logic          rewind,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            base_q <= base;
            addr_q <= base;
        end else if (rewind) begin
            addr_q <= base_q;
        end else if (step && inc_en) begin
            addr_q <= addr_q + AW'(size_bytes(size));
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_item_ctr.sv
module dma_item_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] count,
    input  logic          step,
    input  logic          reload,
    output logic [CW-1:0] left,
    output logic          last,
    output logic          half_hit
);
    logic [CW-1:0] total_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            total_q <= count;
            left_q  <= count;
        end else if (step) begin
            left_q <= (last && reload) ? total_q : left_q - CW'(1);
        end
    end

    always_comb begin
        left     = left_q;
        last     = (left_q == CW'(1));
        half_hit = ((left_q - CW'(1)) == (total_q >> 1));
    end
endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
    import dma_stream_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_dir,
    input  logic [1:0]        cfg_psize,
    input  logic [1:0]        cfg_msize,
    input  logic              cfg_pinc,
    input  logic              cfg_minc,
    input  logic              cfg_circ,
    input  logic [AW-1:0]     cfg_paddr,
    input  logic [AW-1:0]     cfg_maddr,
    input  logic [CW-1:0]     cfg_count,
    input  logic [NFLAGS-1:0] cfg_ie,
    input  logic              start,
    input  logic              stop,
    input  logic [NFLAGS-1:0] flag_clr,
    output logic [NFLAGS-1:0] flags,
    output logic              irq,
    output logic              busy_en,
    output logic [CW-1:0]     items_left,
    input  logic              prq,
    output logic              prq_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DW-1:0]     bus_rdata
);
    mode_t             cfg_mode;
    mode_t             mode_q;
    state_e            state_q;
    logic              en_q;
    logic              stop_pend_q;
    logic              pend_q;
    logic [DW-1:0]     dbuf_q;
    logic [NFLAGS-1:0] flags_q;
    logic [NFLAGS-1:0] flag_set;

    logic          cfg_ok, start_go, launch;
    logic          m2m, src_is_p, on_bus;
    logic          rd_done, wr_done, item_ok, xfer_err, wrap, overrun;
    logic          last, half_hit;
    logic [AW-1:0] paddr, maddr, src_addr, dst_addr;
    size_e         src_size, dst_size;

    always_comb begin
        cfg_mode.dir   = dir_e'(cfg_dir);
        cfg_mode.psize = size_e'(cfg_psize);
        cfg_mode.msize = size_e'(cfg_msize);
        cfg_mode.pinc  = cfg_pinc;
        cfg_mode.minc  = cfg_minc;
        cfg_mode.circ  = cfg_circ;
    end

    dma_cfg_check #(.AW(AW), .CW(CW)) i_cfg (
        .mode  (cfg_mode),
        .paddr (cfg_paddr),
        .maddr (cfg_maddr),
        .count (cfg_count),
        .ok    (cfg_ok)
    );

    always_comb begin
        start_go = start && !en_q;
        launch   = start_go && cfg_ok;
        m2m      = (mode_q.dir == DIR_M2M);
        src_is_p = (mode_q.dir != DIR_M2P);
        on_bus   = (state_q == ST_READ) || (state_q == ST_WRITE);
        rd_done  = (state_q == ST_READ) && bus_ack;
        wr_done  = (state_q == ST_WRITE) && bus_ack;
        item_ok  = wr_done && !bus_err;
        xfer_err = (rd_done || wr_done) && bus_err;
        wrap     = item_ok && last && mode_q.circ;
        overrun  = prq && en_q && !m2m && (pend_q || on_bus);
        src_addr = src_is_p ? paddr : maddr;
        dst_addr = src_is_p ? maddr : paddr;
        src_size = src_is_p ? mode_q.psize : mode_q.msize;
        dst_size = src_is_p ? mode_q.msize : mode_q.psize;
    end

    dma_addr_gen #(.AW(AW)) i_paddr (
        .clk    (clk),
        .rst    (rst),
        .load   (launch),
        .base   (cfg_paddr),
        .inc_en (mode_q.pinc),
        .size   (mode_q.psize),
        .step   (item_ok),
        .rewind (wrap),
        .addr   (paddr)
    );

    dma_addr_gen #(.AW(AW)) i_maddr (
        .clk    (clk),
        .rst    (rst),
        .load   (launch),
        .base   (cfg_maddr),
        .inc_en (mode_q.minc),
        .size   (mode_q.msize),
        .step   (item_ok),
        .rewind (wrap),
        .addr   (maddr)
    );

    dma_item_ctr #(.CW(CW)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .count    (cfg_count),
        .step     (item_ok),
        .reload   (mode_q.circ),
        .left     (items_left),
        .last     (last),
        .half_hit (half_hit)
    );

    // Stream sequencing: wait for a request, read the source, write the destination.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            en_q        <= 1'b0;
            mode_q      <= '0;
            stop_pend_q <= 1'b0;
            pend_q      <= 1'b0;
            dbuf_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    pend_q      <= 1'b0;
                    stop_pend_q <= 1'b0;
                    if (launch) begin
                        mode_q  <= cfg_mode;
                        en_q    <= 1'b1;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (stop) begin
                        en_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end else if (m2m || pend_q) begin
                        pend_q  <= 1'b0;
                        state_q <= ST_READ;
                    end else if (prq) begin
                        pend_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (stop) stop_pend_q <= 1'b1;
                    if (bus_ack) begin
                        if (bus_err) begin
                            en_q    <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            dbuf_q  <= bus_rdata;
                            state_q <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (stop) stop_pend_q <= 1'b1;
                    if (bus_ack) begin
                        if (bus_err || (last && !mode_q.circ) || stop_pend_q || stop) begin
                            en_q    <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_TC]  = item_ok && last;
        flag_set[FLAG_HT]  = item_ok && half_hit;
        flag_set[FLAG_TE]  = xfer_err;
        flag_set[FLAG_DME] = overrun;
        flag_set[FLAG_FE]  = start_go && !cfg_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    always_comb begin
        flags     = flags_q;
        irq       = |(flags_q & cfg_ie);
        busy_en   = en_q;
        prq_ack   = item_ok && !m2m;
        bus_req   = on_bus;
        bus_we    = (state_q == ST_WRITE);
        bus_addr  = (state_q == ST_WRITE) ? dst_addr : src_addr;
        bus_size  = (state_q == ST_WRITE) ? dst_size : src_size;
        bus_wdata = dbuf_q;
    end
endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy_en,
    input logic          bus_req,
    input logic          bus_ack,
    input logic          bus_err,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [4:0]    flags,
    input logic [CW-1:0] items_left,
    input logic          prq_ack
);
    // R1: an access holds its request, address and kind until answered
    a_r1_hold_access: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R7: enable only drops when no access was left unanswered
    a_r7_no_abort: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_en) |-> ($past(bus_ack) || !$past(bus_req)));

    // R7: bus traffic only while enabled
    a_r7_req_needs_en: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy_en);

    // R8: an error response sets the error flag and disables
    a_r8_err_stops: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_err) |=> (flags[2] && !busy_en));

    // R3: completion only on the step from one item left
    a_r3_tc_at_last: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> ($past(items_left) == CW'(1)));

    // R6: a configuration error never leaves the stream enabled
    a_r6_fe_disabled: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[4]) |-> !busy_en);

    // R13: the peripheral acknowledge marks a successful write
    a_r13_ack_on_write: assert property (@(posedge clk) disable iff (rst)
        prq_ack |-> (bus_req && bus_we && bus_ack && !bus_err));
endmodule

bind dma_stream_engine dma_stream_chk #(.AW(AW), .CW(CW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_en    (busy_en),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .flags      (flags),
    .items_left (items_left),
    .prq_ack    (prq_ack)
);

// File: tb/test_dma_stream_engine.sv
module test_dma_stream_engine;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam logic [31:0] PBASE = 32'h4000_1000;
    localparam logic [31:0] MBASE = 32'h2000_0200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_dir = 0, cfg_psize = 0, cfg_msize = 0;
    logic cfg_pinc = 0, cfg_minc = 0, cfg_circ = 0;
    logic [AW-1:0] cfg_paddr = PBASE, cfg_maddr = MBASE;
    logic [CW-1:0] cfg_count = 0;
    logic [4:0] cfg_ie = 0, flag_clr = 0, flags;
    logic start = 0, stop = 0, prq = 0;
    logic irq, busy_en, prq_ack, bus_req, bus_we;
    logic [CW-1:0] items_left;
    logic [AW-1:0] bus_addr;
    logic [1:0] bus_size;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic bus_ack = 0, bus_err = 0;

    int nchk = 0, nfail = 0;
    int ack_num = 0, err_at = -1;
    int wn = 0, pack_cnt = 0;
    logic [31:0] wl_addr [64];
    logic [31:0] wl_data [64];
    logic [1:0]  wl_size [64];

    always #2 clk = ~clk;

    dma_stream_engine #(.AW(AW), .DW(DW), .CW(CW)) i_dma_stream_engine (.*);

    function automatic logic [31:0] rd_val(logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    function automatic logic [31:0] sz_mask(int s);
        return (s == 0) ? 32'h0000_00FF : (s == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    assign bus_rdata = rd_val(bus_addr);

    // Responder: answers every other cycle, optionally with an error.
    initial forever begin
        @(negedge clk);
        if (bus_ack) ack_num = ack_num + 1;
        bus_ack = bus_req && !bus_ack;
        bus_err = bus_ack && (ack_num == err_at);
    end

    always @(posedge clk) begin
        if (bus_req && bus_ack && bus_we && !bus_err) begin
            if (wn < 64) begin
                wl_addr[wn] = bus_addr;
                wl_data[wn] = bus_wdata;
                wl_size[wn] = bus_size;
            end
            wn = wn + 1;
        end
        if (prq_ack) pack_cnt = pack_cnt + 1;
    end

    initial begin
        #(4 * 150000);
        nfail = nfail + 1;
        $display("FAIL watchdog act=hung exp=done");
        $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); flag_clr = 5'h1F;
        @(negedge clk); flag_clr = 5'h00;
    endtask

    task automatic setup(input int dir, input int sz, input bit pi, input bit mi,
                         input int cnt, input bit circ);
        cfg_dir = 2'(dir); cfg_psize = 2'(sz); cfg_msize = 2'(sz);
        cfg_pinc = pi; cfg_minc = mi; cfg_count = CW'(cnt); cfg_circ = circ;
        cfg_paddr = PBASE; cfg_maddr = MBASE;
        wn = 0; pack_cnt = 0; ack_num = 0; err_at = -1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_prq();
        @(negedge clk); prq = 1'b1;
        @(negedge clk); prq = 1'b0;
    endtask

    task automatic wait_writes(input int n);
        while (wn < n) @(negedge clk);
    endtask

    // Full block in one configuration, checked item by item.
    task automatic sweep_one(input int dir, input int sz, input bit pi, input bit mi, input int cnt);
        logic [31:0] sb, db, sa, da;
        bit si, di, ok;
        int nb;
        setup(dir, sz, pi, mi, cnt, 1'b0);
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        sb = (dir == 1) ? MBASE : PBASE;
        db = (dir == 1) ? PBASE : MBASE;
        si = (dir == 1) ? mi : pi;
        di = (dir == 1) ? pi : mi;
        pulse_start();
        for (int k = 0; k < cnt; k++) begin
            if (dir != 2) pulse_prq();
            wait_writes(k + 1);
            sa = sb + (si ? 32'(k * nb) : 32'd0);
            da = db + (di ? 32'(k * nb) : 32'd0);
            ok = (wl_addr[k] == da) && (wl_size[k] == 2'(sz)) &&
                 ((wl_data[k] & sz_mask(sz)) == (rd_val(sa) & sz_mask(sz)));
            chk(ok, "R1/R2 write addr", {32'(wl_addr[k]), wl_data[k]}, {da, rd_val(sa)});
            chk(items_left == CW'(cnt - k - 1), "R3 items_left", 64'(items_left), 64'(cnt - k - 1));
            chk(flags[1] == ((cnt - k - 1) <= (cnt / 2)), "R4 half flag", 64'(flags[1]),
                64'((cnt - k - 1) <= (cnt / 2)));
            chk(flags[0] == (k == cnt - 1), "R3 complete flag", 64'(flags[0]), 64'(k == cnt - 1));
        end
        tick(2);
        chk(!busy_en && !bus_req && wn == cnt, "R3 normal stop", 64'(busy_en), 64'd0);
        chk(pack_cnt == ((dir == 2) ? 0 : cnt), "R13 prq_ack count", 64'(pack_cnt),
            64'((dir == 2) ? 0 : cnt));
        clear_all();
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        chk(flags == 0 && !busy_en && !bus_req && !irq && items_left == 0,
            "reset state", 64'({flags, busy_en, bus_req, irq}), 64'd0);

        // Sweep: directions, sizes, increment pairings, counts.
        for (int d = 0; d < 3; d++)
            for (int s = 0; s < 3; s++)
                for (int inc = 0; inc < 4; inc++)
                    for (int ci = 0; ci < 4; ci++)
                        sweep_one(d, s, inc[0], inc[1], (ci == 3) ? 5 : ci + 1);

        // R1: peripheral direction idles without a request; R7 stop while waiting.
        setup(0, 2, 1, 1, 4, 0);
        pulse_start();
        tick(4);
        chk(busy_en && !bus_req, "R1 waits for prq", 64'(bus_req), 64'd0);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(!busy_en && wn == 0, "R7 stop while waiting", 64'(busy_en), 64'd0);
        clear_all();

        // R7: stop during a read finishes that item first.
        setup(2, 2, 1, 1, 8, 0);
        pulse_start();
        while (!(bus_req && !bus_we)) @(negedge clk);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(busy_en == 1'b1, "R7 enable held in flight", 64'(busy_en), 64'd1);
        tick(6);
        chk(!busy_en && wn == 1 && items_left == 7 && !flags[0], "R7 deferred stop",
            64'(wn), 64'd1);
        clear_all();

        // R8 / R11 / R10: error on the read of item 2.
        setup(2, 2, 1, 1, 6, 0);
        err_at = 4;
        cfg_ie = 5'b00000;
        pulse_start();
        tick(16);
        chk(flags[2] && !busy_en, "R8 error flag and disable", 64'({flags[2], busy_en}), 64'b10);
        chk(wn == 2 && items_left == 4, "R8 no write after failed read", 64'(wn), 64'd2);
        chk(!irq, "R11 masked irq", 64'(irq), 64'd0);
        cfg_ie = 5'b00100;
        tick(1);
        chk(irq, "R11 enabled irq", 64'(irq), 64'd1);
        @(negedge clk); flag_clr = 5'b00100;
        @(negedge clk); flag_clr = 5'b00000;
        chk(!flags[2] && !irq, "R10 clear error flag", 64'(flags), 64'd0);
        cfg_ie = 5'b00000;
        clear_all();

        // R10: clearing one flag leaves the others.
        setup(2, 0, 1, 1, 2, 0);
        pulse_start();
        wait_writes(2);
        tick(1);
        @(negedge clk); flag_clr = 5'b00001;
        @(negedge clk); flag_clr = 5'b00000;
        chk(flags == 5'b00010, "R10 selective clear", 64'(flags), 64'b00010);
        clear_all();

        // R9: an extra request while a read is on the bus.
        setup(0, 0, 0, 1, 3, 0);
        pulse_start();
        pulse_prq();
        while (!bus_req) @(negedge clk);
        prq = 1'b1;
        @(negedge clk); prq = 1'b0;
        wait_writes(1);
        tick(3);
        chk(flags[3] && wn == 1, "R9 overrun flag, pulse dropped", 64'({flags[3], 8'(wn)}), 64'h101);
        pulse_prq(); wait_writes(2);
        pulse_prq(); wait_writes(3);
        tick(2);
        chk(!busy_en && flags[0], "R9 block still completes", 64'(busy_en), 64'd0);
        clear_all();

        // R5: circular mode wraps count and memory address.
        setup(0, 1, 0, 1, 3, 1);
        pulse_start();
        for (int k = 0; k < 7; k++) begin
            pulse_prq();
            wait_writes(k + 1);
            chk(wl_addr[k] == MBASE + 32'((k % 3) * 2), "R5 wrapped address",
                64'(wl_addr[k]), 64'(MBASE + 32'((k % 3) * 2)));
        end
        tick(1);
        chk(busy_en && flags[0] && items_left == 2, "R5 still enabled after wrap",
            64'({busy_en, flags[0], items_left}), {46'd0, 2'b11, 16'd2});
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        clear_all();

        // R12: restart ignored and configuration captured.
        setup(0, 0, 0, 1, 2, 0);
        pulse_start();
        cfg_maddr = 32'h3000_0000;
        cfg_count = CW'(9);
        pulse_start();
        chk(flags[4] == 1'b0 && items_left == 2, "R12 restart ignored", 64'(items_left), 64'd2);
        pulse_prq(); wait_writes(1);
        pulse_prq(); wait_writes(2);
        tick(2);
        chk(wl_addr[0] == MBASE && wl_addr[1] == MBASE + 1 && !busy_en,
            "R12 captured config", 64'(wl_addr[1]), 64'(MBASE + 1));
        clear_all();

        // R6: each rejected configuration.
        for (int c = 0; c < 6; c++) begin
            setup(2, 2, 1, 1, 4, 0);
            case (c)
                0: cfg_dir = 2'd3;
                1: begin cfg_psize = 2'd3; cfg_msize = 2'd3; end
                2: cfg_msize = 2'd1;
                3: cfg_count = '0;
                4: cfg_circ = 1'b1;
                default: cfg_paddr = PBASE + 32'd2;
            endcase
            pulse_start();
            chk(!busy_en && flags[4] && !bus_req, "R6 rejected start",
                64'({busy_en, flags[4]}), 64'b01);
            tick(3);
            chk(wn == 0 && !bus_req, "R6 no bus access", 64'(wn), 64'd0);
            clear_all();
        end

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule